// File: doc/BRIEF.md
# Operand Hazard Resolution and Bypass Unit

This block keeps a five-stage in-order load-store pipeline (fetch, decode, execute, memory, writeback) free of read-after-write errors. It holds the decode/execute, execute/memory and memory/writeback pipeline registers for the operand and control fields, and the architectural register file. The ALU sits outside. The block presents the execute-stage operands on `ex_op_a` and `ex_op_b` and takes the sum or result back on `ex_alu_res`. The data memory also sits outside. It is addressed from the execute/memory register, and its read data comes back on `mem_rdata`.

Each cycle the block compares the source specifiers of the decode-stage instruction with the destinations held further down the pipe. From that comparison it raises `stall`, which tells fetch and decode to hold, and it loads a no-op into the execute stage. It also compares the source specifiers of the execute-stage instruction with the execute/memory and memory/writeback destinations, and selects a bypass source for each ALU input. The register file writes in the first half of the cycle and reads in the second half, so a value retiring at writeback reaches decode in the same cycle.

The parameter `FWD_EN` selects between two modes. With it set, a dependent ALU instruction never waits and a load costs one bubble. With it clear, nothing is bypassed, and a consumer waits in decode until its producer reaches writeback.

Top module: `hzd_pipe_unit`

## Requirements
- R1: The register file has two read ports and one write port driven from writeback. A register read in decode in the same cycle it is written at writeback returns the new value, so a dependence three instructions apart needs neither a stall nor a bypass, and its select is 0.
- R2: Register 0 always reads as zero. A write naming it has no effect. A consumer reading it never stalls and is never bypassed, even when the instruction just before it names register 0 as its destination with its write enable set.
- R3: With `FWD_EN`=1, an ALU result feeds the next instructions without a stall. The select codes are 0 for the register-file value, 1 for the execute/memory result and 2 for the memory/writeback result. A dependence one instruction back uses code 1 and one two instructions back uses code 2.
- R4: When the execute/memory and memory/writeback destinations both match a source, the execute/memory (younger) value wins.
- R5: With `FWD_EN`=1, a load followed at once by a consumer of its result costs exactly one stall cycle. The value then reaches the consumer through the memory/writeback bypass (code 2), and a load result is never taken from the execute/memory register.
- R6: With `FWD_EN`=0, a consumer stalls in decode until its producer is at writeback. That is two stall cycles at a distance of one, one stall cycle at a distance of two, and none from three on, for ALU results and loads alike. Every select stays 0.
- R7: While `stall` is high, the block expects fetch and decode to hold their instruction. It loads a no-op with all write enables cleared into the execute stage, so `ex_bubble` is high in the following cycle, and a bubble never reaches the memory write or read strobe.
- R8: A destination takes part in a comparison only when its instruction's register-write enable is set. A store, whose write enable is clear, never causes a stall or a bypass, even when its destination field equals a later source.
- R9: Operand B is the immediate when `id_use_imm` is set, and otherwise the register value, bypassed if needed. Store data is the bypassed second source.
- R10: While reset is held, `stall` is low, `ex_bubble` is high, and `wb_wen`, `mem_wr_en` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | AW | First source specifier in decode |
| id_rs2 | input | AW | Second source specifier in decode |
| id_rd | input | AW | Destination specifier in decode |
| id_wen | input | 1 | Decode instruction writes a register |
| id_is_load | input | 1 | Decode instruction is a load |
| id_is_store | input | 1 | Decode instruction is a store |
| id_use_imm | input | 1 | Operand B is the immediate |
| id_imm | input | DATA_W | Immediate value |
| ex_alu_res | input | DATA_W | ALU result for the execute-stage instruction |
| mem_rdata | input | DATA_W | Data memory read data for the memory stage |
| stall | output | 1 | Hold fetch and decode this cycle |
| ex_bubble | output | 1 | Execute stage holds a no-op |
| ex_fwd_a | output | 2 | Bypass select for operand A |
| ex_fwd_b | output | 2 | Bypass select for the second register source |
| ex_op_a | output | DATA_W | ALU operand A |
| ex_op_b | output | DATA_W | ALU operand B |
| ex_store_data | output | DATA_W | Bypassed store data in execute |
| mem_addr | output | DATA_W | Data memory address |
| mem_wdata | output | DATA_W | Data memory write data |
| mem_rd_en | output | 1 | Memory stage holds a load |
| mem_wr_en | output | 1 | Memory stage holds a store |
| wb_wen | output | 1 | Writeback writes the register file |
| wb_rd | output | AW | Writeback destination |
| wb_data | output | DATA_W | Writeback value |

## Verification
The bound checker watches several properties on every cycle. A stall is always followed by a bubble in execute. In bypass mode a stall never lasts two cycles. A bubble never turns into a memory access. A load sitting in the memory stage is never picked as a bypass source, and with bypassing disabled every select stays 0.

Other behaviours show only over a whole instruction sequence, and the bench's scenarios cover them. These are the exact stall counts at each producer distance, the select code a given distance produces, the younger-wins priority, the same-cycle write-through, and architectural register values that match a sequential model. The bench sweeps both modes and both producer kinds (ALU and load) over distances 1 to 4 on each operand slot, so every one of these cases is driven.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Bypass source select for an execute-stage operand.
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } opsrc_e;
endpackage

// File: rtl/hzd_regfile.sv
// Register file: NRD synchronous read ports, one write port.
// The write is visible to a read addressed in the same cycle.
// Entry 0 reads as zero and is never written.
module hzd_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter int NRD    = 2,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic [NRD-1:0][AW-1:0]       rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]   rd_q,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DATA_W-1:0]            wr_data
);
  logic [DATA_W-1:0] store_q [NREG];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr != '0)) begin
      store_q[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic same_slot;
    assign same_slot = wr_en && (wr_addr == rd_addr[p]);
    always_ff @(posedge clk) begin
      if (rd_addr[p] == '0) begin
        rd_q[p] <= '0;
      end else if (same_slot) begin
        rd_q[p] <= wr_data;
      end else begin
        rd_q[p] <= store_q[rd_addr[p]];
      end
    end
  end
endmodule

// File: rtl/hzd_fwd_mux.sv
// Bypass selection for one execute-stage operand. Younger stage wins.
module hzd_fwd_mux
  import hzd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic [AW-1:0]     src,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              em_wen,
  input  logic              em_ld,
  input  logic [AW-1:0]     em_rd,
  input  logic [DATA_W-1:0] em_val,
  input  logic              mw_wen,
  input  logic [AW-1:0]     mw_rd,
  input  logic [DATA_W-1:0] mw_val,
  output opsrc_e            sel,
  output logic [DATA_W-1:0] val
);
  logic src_live, em_hit, mw_hit;

  assign src_live = (src != '0);
  // A load in execute/memory has no data yet; its consumer was stalled.
  assign em_hit = FWD_EN && src_live && em_wen && !em_ld && (em_rd == src);
  assign mw_hit = FWD_EN && src_live && mw_wen && (mw_rd == src);

  always_comb begin
    if (em_hit) begin
      sel = SRC_EXMEM;
      val = em_val;
    end else if (mw_hit) begin
      sel = SRC_MEMWB;
      val = mw_val;
    end else begin
      sel = SRC_RF;
      val = rf_val;
    end
  end
endmodule

// File: rtl/hzd_stall_det.sv
// Decode-stage read-after-write detector.
module hzd_stall_det #(
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic          id_valid,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_uses_rs2,
  input  logic          ex_wen,
  input  logic          ex_ld,
  input  logic [AW-1:0] ex_rd,
  input  logic          mm_wen,
  input  logic [AW-1:0] mm_rd,
  output logic          stall
);
  logic hit_ex, hit_mm, need_hold;

  assign hit_ex = ex_wen && (ex_rd != '0) &&
                  ((id_rs1 == ex_rd) || (id_uses_rs2 && (id_rs2 == ex_rd)));
  assign hit_mm = mm_wen && (mm_rd != '0) &&
                  ((id_rs1 == mm_rd) || (id_uses_rs2 && (id_rs2 == mm_rd)));

  // With bypassing only a load one step ahead blocks; without it, any
  // producer not yet at writeback blocks.
  assign need_hold = FWD_EN ? (hit_ex && ex_ld) : (hit_ex || hit_mm);
  assign stall     = id_valid && need_hold;
endmodule

// File: rtl/hzd_pipe_unit.sv
module hzd_pipe_unit
  import hzd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 32,
  parameter bit FWD_EN = 1'b1,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [AW-1:0]     id_rs1,
  input  logic [AW-1:0]     id_rs2,
  input  logic [AW-1:0]     id_rd,
  input  logic              id_wen,
  input  logic              id_is_load,
  input  logic              id_is_store,
  input  logic              id_use_imm,
  input  logic [DATA_W-1:0] id_imm,
  input  logic [DATA_W-1:0] ex_alu_res,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              stall,
  output logic              ex_bubble,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b,
  output logic [DATA_W-1:0] ex_op_a,
  output logic [DATA_W-1:0] ex_op_b,
  output logic [DATA_W-1:0] ex_store_data,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              wb_wen,
  output logic [AW-1:0]     wb_rd,
  output logic [DATA_W-1:0] wb_data
);
  localparam int NSRC = 2;

  typedef struct packed {
    logic              v;
    logic              wen;
    logic              ld;
    logic              st;
    logic              isel;
    logic [AW-1:0]     rs1;
    logic [AW-1:0]     rs2;
    logic [AW-1:0]     rd;
    logic [DATA_W-1:0] imm;
  } dx_t;

  typedef struct packed {
    logic              wen;
    logic              ld;
    logic              st;
    logic [AW-1:0]     rd;
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] sdata;
  } xm_t;

  typedef struct packed {
    logic              wen;
    logic [AW-1:0]     rd;
    logic [DATA_W-1:0] data;
  } mw_t;

  dx_t dx_q;
  xm_t xm_q;
  mw_t mw_q;

  logic                         uses_rs2;
  logic [NSRC-1:0][AW-1:0]      rf_addr;
  logic [NSRC-1:0][DATA_W-1:0]  rf_q;
  logic [NSRC-1:0][AW-1:0]      ex_src;
  logic [NSRC-1:0][DATA_W-1:0]  byp_val;
  opsrc_e                       byp_sel [NSRC];

  // ---------------- decode: hazard detection ----------------
  assign uses_rs2 = !id_use_imm || id_is_store;

  hzd_stall_det #(
    .AW     (AW),
    .FWD_EN (FWD_EN)
  ) u_det (
    .id_valid    (id_valid),
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .id_uses_rs2 (uses_rs2),
    .ex_wen      (dx_q.wen),
    .ex_ld       (dx_q.ld),
    .ex_rd       (dx_q.rd),
    .mm_wen      (xm_q.wen),
    .mm_rd       (xm_q.rd),
    .stall       (stall)
  );

  // ---------------- register file (read in decode) ----------------
  assign rf_addr[0] = id_rs1;
  assign rf_addr[1] = id_rs2;

  hzd_regfile #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .NRD    (NSRC)
  ) u_rf (
    .clk     (clk),
    .rd_addr (rf_addr),
    .rd_q    (rf_q),
    .wr_en   (mw_q.wen),
    .wr_addr (mw_q.rd),
    .wr_data (mw_q.data)
  );

  // ---------------- decode/execute register ----------------
  always_ff @(posedge clk) begin
    if (rst || stall || !id_valid) begin
      dx_q <= '0;
    end else begin
      dx_q.v    <= 1'b1;
      dx_q.wen  <= id_wen;
      dx_q.ld   <= id_is_load;
      dx_q.st   <= id_is_store;
      dx_q.isel <= id_use_imm;
      dx_q.rs1  <= id_rs1;
      dx_q.rs2  <= id_rs2;
      dx_q.rd   <= id_rd;
      dx_q.imm  <= id_imm;
    end
  end

  // ---------------- execute: operand bypass ----------------
  assign ex_src[0] = dx_q.rs1;
  assign ex_src[1] = dx_q.rs2;

  for (genvar s = 0; s < NSRC; s++) begin : g_byp
    hzd_fwd_mux #(
      .DATA_W (DATA_W),
      .AW     (AW),
      .FWD_EN (FWD_EN)
    ) u_mux (
      .src    (ex_src[s]),
      .rf_val (rf_q[s]),
      .em_wen (xm_q.wen),
      .em_ld  (xm_q.ld),
      .em_rd  (xm_q.rd),
      .em_val (xm_q.res),
      .mw_wen (mw_q.wen),
      .mw_rd  (mw_q.rd),
      .mw_val (mw_q.data),
      .sel    (byp_sel[s]),
      .val    (byp_val[s])
    );
  end

  assign ex_bubble     = !dx_q.v;
  assign ex_fwd_a      = byp_sel[0];
  assign ex_fwd_b      = byp_sel[1];
  assign ex_op_a       = byp_val[0];
  assign ex_store_data = byp_val[1];
  assign ex_op_b       = dx_q.isel ? dx_q.imm : byp_val[1];

  // ---------------- execute/memory register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      xm_q <= '0;
    end else begin
      xm_q.wen   <= dx_q.wen;
      xm_q.ld    <= dx_q.ld;
      xm_q.st    <= dx_q.st;
      xm_q.rd    <= dx_q.rd;
      xm_q.res   <= ex_alu_res;
      xm_q.sdata <= byp_val[1];
    end
  end

  assign mem_addr  = xm_q.res;
  assign mem_wdata = xm_q.sdata;
  assign mem_rd_en = xm_q.ld;
  assign mem_wr_en = xm_q.st;

  // ---------------- memory/writeback register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      mw_q <= '0;
    end else begin
      mw_q.wen  <= xm_q.wen && (xm_q.rd != '0);
      mw_q.rd   <= xm_q.rd;
      mw_q.data <= xm_q.ld ? mem_rdata : xm_q.res;
    end
  end

  assign wb_wen  = mw_q.wen;
  assign wb_rd   = mw_q.rd;
  assign wb_data = mw_q.data;
endmodule

// File: rtl/hzd_pipe_unit_chk.sv
module hzd_pipe_unit_chk #(
  parameter bit FWD_EN = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       stall,
  input logic       ex_bubble,
  input logic [1:0] ex_fwd_a,
  input logic [1:0] ex_fwd_b,
  input logic       mem_rd_en,
  input logic       mem_wr_en
);
  // R7: a stalled decode always leaves a no-op in execute.
  assert_stall_bubbles_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> ex_bubble);

  // R7: a no-op never becomes a memory access.
  assert_bubble_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ex_bubble |=> (!mem_wr_en && !mem_rd_en));

  // R8: a no-op in execute has no live sources, so nothing is bypassed.
  assert_bubble_no_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    ex_bubble |-> (ex_fwd_a == 2'd0 && ex_fwd_b == 2'd0));

  // R5: load data is never taken from the execute/memory register.
  assert_no_early_load_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (ex_fwd_a != 2'd1 && ex_fwd_b != 2'd1));

  if (FWD_EN) begin : g_fwd
    // R5: a load-use hazard costs one cycle, never two in a row.
    assert_single_stall_R5: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall);
  end else begin : g_nofwd
    // R6: with bypassing off every operand comes from the register file.
    assert_no_bypass_R6: assert property (@(posedge clk) disable iff (rst)
      (ex_fwd_a == 2'd0) && (ex_fwd_b == 2'd0));
  end
endmodule

bind hzd_pipe_unit hzd_pipe_unit_chk #(.FWD_EN(FWD_EN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .ex_bubble (ex_bubble),
  .ex_fwd_a  (ex_fwd_a),
  .ex_fwd_b  (ex_fwd_b),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en)
);

// File: tb/hzd_pipe_unit_tb_top.sv
module hzd_pipe_unit_tb_top;
  localparam int DW = 16;
  localparam int NR = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic mode;
  logic id_valid;
  logic [AW-1:0] id_rs1, id_rs2, id_rd;
  logic id_wen, id_ld, id_st, id_isel;
  logic [DW-1:0] id_imm;

  // outputs of the bypassing instance (f_) and the non-bypassing one (n_)
  logic f_stall, f_bub, f_rd, f_wr, f_wbw;
  logic [1:0] f_fa, f_fb;
  logic [DW-1:0] f_a, f_b, f_sd, f_addr, f_wd, f_wbd, f_rdata;
  logic [AW-1:0] f_wbr;
  logic n_stall, n_bub, n_rd, n_wr, n_wbw;
  logic [1:0] n_fa, n_fb;
  logic [DW-1:0] n_a, n_b, n_sd, n_addr, n_wd, n_wbd, n_rdata;
  logic [AW-1:0] n_wbr;

  logic [DW-1:0] dm_f [16];
  logic [DW-1:0] dm_n [16];
  logic [DW-1:0] mdl_reg [NR];
  logic [DW-1:0] mdl_mem [16];

  assign f_rdata = dm_f[f_addr[3:0]];
  assign n_rdata = dm_n[n_addr[3:0]];

  always_ff @(posedge clk) begin
    if (f_wr) dm_f[f_addr[3:0]] <= f_wd;
    if (n_wr) dm_n[n_addr[3:0]] <= n_wd;
  end

  hzd_pipe_unit #(.DATA_W(DW), .NREG(NR), .FWD_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .id_valid(id_valid && !mode),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd), .id_wen(id_wen),
    .id_is_load(id_ld), .id_is_store(id_st), .id_use_imm(id_isel), .id_imm(id_imm),
    .ex_alu_res(f_a + f_b), .mem_rdata(f_rdata),
    .stall(f_stall), .ex_bubble(f_bub), .ex_fwd_a(f_fa), .ex_fwd_b(f_fb),
    .ex_op_a(f_a), .ex_op_b(f_b), .ex_store_data(f_sd),
    .mem_addr(f_addr), .mem_wdata(f_wd), .mem_rd_en(f_rd), .mem_wr_en(f_wr),
    .wb_wen(f_wbw), .wb_rd(f_wbr), .wb_data(f_wbd)
  );

  hzd_pipe_unit #(.DATA_W(DW), .NREG(NR), .FWD_EN(1'b0)) dut_nf_i (
    .clk(clk), .rst(rst), .id_valid(id_valid && mode),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd), .id_wen(id_wen),
    .id_is_load(id_ld), .id_is_store(id_st), .id_use_imm(id_isel), .id_imm(id_imm),
    .ex_alu_res(n_a + n_b), .mem_rdata(n_rdata),
    .stall(n_stall), .ex_bubble(n_bub), .ex_fwd_a(n_fa), .ex_fwd_b(n_fb),
    .ex_op_a(n_a), .ex_op_b(n_b), .ex_store_data(n_sd),
    .mem_addr(n_addr), .mem_wdata(n_wd), .mem_rd_en(n_rd), .mem_wr_en(n_wr),
    .wb_wen(n_wbw), .wb_rd(n_wbr), .wb_data(n_wbd)
  );

  logic c_stall, c_bub;
  logic [1:0] c_fa, c_fb;
  logic [DW-1:0] c_a, c_b;
  assign c_stall = mode ? n_stall : f_stall;
  assign c_bub   = mode ? n_bub   : f_bub;
  assign c_fa    = mode ? n_fa    : f_fa;
  assign c_fb    = mode ? n_fb    : f_fb;
  assign c_a     = mode ? n_a     : f_a;
  assign c_b     = mode ? n_b     : f_b;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d actual=%0d expected=%0d", req, mode, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Present one instruction in decode and hold it while stalled.
  task automatic issue(input logic [AW-1:0] rs1, input logic [AW-1:0] rs2,
                       input logic [AW-1:0] rd, input logic wen, input logic ld,
                       input logic st, input logic isel, input logic [DW-1:0] imm,
                       output int ns);
    logic [DW-1:0] a, b, ea;
    @(negedge clk);
    id_valid = 1'b1; id_rs1 = rs1; id_rs2 = rs2; id_rd = rd;
    id_wen = wen; id_ld = ld; id_st = st; id_isel = isel; id_imm = imm;
    #1;
    ns = 0;
    while (c_stall) begin
      ns++;
      @(negedge clk);
      #1;
      check("R7 bubble after stall", c_bub, 1);
    end
    a  = mdl_reg[rs1];
    b  = isel ? imm : mdl_reg[rs2];
    ea = a + imm;
    if (st) mdl_mem[ea[3:0]] = mdl_reg[rs2];
    if (wen && rd != '0) mdl_reg[rd] = ld ? mdl_mem[ea[3:0]] : a + b;
    mdl_reg[0] = '0;
  endtask

  // Leave decode empty for a cycle; the last issued instruction is then in execute.
  task automatic peek();
    @(negedge clk);
    id_valid = 1'b0;
    #1;
  endtask

  task automatic readout(input logic [AW-1:0] k, input string req);
    int ns;
    issue(k, 0, 0, 0, 0, 0, 1, 0, ns);
    peek();
    check(req, c_a, mdl_reg[k]);
  endtask

  task automatic run_suite(input int m);
    int ns, tot, exp_ns, exp_sel;
    logic [AW-1:0] c1, c2;
    string tag;
    // initialise every register from r0 + immediate
    tot = 0;
    for (int k = 1; k < NR; k++) begin
      issue(0, 0, k[AW-1:0], 1, 0, 0, 1, DW'(k * 3 + 1), ns);
      tot += ns;
    end
    check("R2 r0 source never stalls", tot, 0);
    repeat (4) peek();
    for (int k = 1; k < NR; k++) readout(k[AW-1:0], "R1 initial value");

    // R2: write aimed at r0, consumer reads r0 at once
    issue(1, 0, 0, 1, 0, 0, 1, 16'd5, ns);
    issue(0, 0, 0, 0, 0, 0, 1, 0, ns);
    check("R2 stall on r0", ns, 0);
    peek();
    check("R2 r0 value", c_a, 0);
    check("R2 r0 select", c_fa, 0);

    // sweep: producer kind x distance x operand slot
    for (int kind = 0; kind < 2; kind++) begin
      for (int d = 1; d <= 4; d++) begin
        for (int slot = 0; slot < 2; slot++) begin
          if (kind == 0) issue(7, 0, 4, 1, 0, 0, 1, DW'(100 + d * 7 + slot), ns);
          else           issue(0, 0, 4, 1, 1, 0, 1, DW'(d * 2 + slot), ns);
          for (int f = 1; f < d; f++) issue(0, 0, 10, 1, 0, 0, 1, 16'd1, ns);
          c1 = (slot == 0) ? 4'd4 : 4'd6;
          c2 = (slot == 0) ? 4'd6 : 4'd4;
          issue(c1, c2, 5, 1, 0, 0, 0, 0, ns);
          if (m == 0) begin
            exp_ns = (kind == 1 && d == 1) ? 1 : 0;
            exp_sel = (d == 1) ? ((kind == 1) ? 2 : 1) : ((d == 2) ? 2 : 0);
            tag = (kind == 1) ? "R5" : "R3";
          end else begin
            exp_ns = (d < 3) ? 3 - d : 0;
            exp_sel = 0;
            tag = "R6";
          end
          check({tag, " stall count"}, ns, exp_ns);
          peek();
          check({tag, " select"}, (slot == 0) ? c_fa : c_fb, exp_sel);
          readout(5, (d == 3) ? "R1 write-through value" : {tag, " value"});
        end
      end
    end

    // R4: two writes to r4, consumer right after sees the younger
    issue(0, 0, 4, 1, 0, 0, 1, 16'd11, ns);
    issue(0, 0, 4, 1, 0, 0, 1, 16'd22, ns);
    issue(4, 6, 5, 1, 0, 0, 0, 0, ns);
    check("R4 stall count", ns, (m == 0) ? 0 : 2);
    peek();
    check("R4 younger value", c_a, 22);
    check("R4 select", c_fa, (m == 0) ? 1 : 0);
    repeat (3) peek();

    // R8: store whose rd field matches a later source
    issue(0, 6, 4, 0, 0, 1, 1, 16'd9, ns);
    issue(4, 0, 11, 1, 0, 0, 1, 0, ns);
    check("R8 stall count", ns, 0);
    peek();
    check("R8 select", c_fa, 0);
    check("R8 value", c_a, mdl_reg[4]);

    // R9: bypassed store data and immediate operand B
    issue(0, 0, 8, 1, 0, 0, 1, 16'd77, ns);
    issue(0, 8, 0, 0, 0, 1, 1, 16'd3, ns);
    check("R9 store stall count", ns, (m == 0) ? 0 : 2);
    repeat (3) peek();
    issue(0, 0, 9, 1, 1, 0, 1, 16'd3, ns);
    repeat (3) peek();
    readout(9, "R9 stored then loaded");
    check("R9 model", mdl_reg[9], 77);
    issue(1, 2, 11, 1, 0, 0, 1, 16'd1234, ns);
    peek();
    check("R9 immediate operand", c_b, 1234);
    repeat (3) peek();

    // load, two dependent uses, then overwrite the loaded register
    tot = 0;
    issue(0, 0, 1, 1, 1, 0, 1, 16'd5, ns); tot += ns;
    issue(1, 0, 2, 1, 0, 0, 0, 0, ns);     tot += ns;
    issue(1, 2, 3, 1, 0, 0, 0, 0, ns);     tot += ns;
    issue(3, 0, 1, 1, 0, 0, 1, 16'd1, ns); tot += ns;
    check((m == 0) ? "R5 sequence stalls" : "R6 sequence stalls", tot, (m == 0) ? 1 : 6);
    repeat (4) peek();
    for (int k = 0; k < NR; k++) readout(k[AW-1:0], "R1 final register");
  endtask

  initial begin
    rst = 1'b1; mode = 1'b0; id_valid = 1'b0;
    id_rs1 = '0; id_rs2 = '0; id_rd = '0;
    id_wen = 1'b0; id_ld = 1'b0; id_st = 1'b0; id_isel = 1'b0; id_imm = '0;
    for (int i = 0; i < 16; i++) begin
      dm_f[i] = DW'(i * 5 + 2);
      dm_n[i] = DW'(i * 5 + 2);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 stall in reset", {f_stall, n_stall}, 0);
    check("R10 bubble in reset", {f_bub, n_bub}, 2'b11);
    check("R10 writes in reset", {f_wbw, n_wbw, f_wr, n_wr, f_rd, n_rd}, 0);
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      mode = m[0];
      for (int i = 0; i < 16; i++) mdl_mem[i] = m[0] ? dm_n[i] : dm_f[i];
      for (int k = 0; k < NR; k++) mdl_reg[k] = '0;
      run_suite(m);
      repeat (4) peek();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule